// File: doc/BRIEF.md
# Linear-Search Longest Prefix Matcher

This engine resolves a 32-bit destination address against a routing table kept in a block RAM beside it. A one-cycle `start` pulse latches the search key. The engine then reads the table one word per cycle, from the lowest entry to the highest. For each entry it fetches three words: the prefix address, the contiguous mask, and the word that holds the valid flag and the port. It tests whether the entry matches the key, and it keeps the index of the matching entry with the longest prefix found so far.

Each table entry takes four 32-bit words. The fourth word holds the next hop, and the scan never fetches it. Index 0 is reserved and is returned when no entry matches. When the last entry has been judged, `done` is high for one cycle and `matchIdx` carries the winning index. The index holds until the next search starts.

Top module: `lpm_scanner`

## Requirements
- R1: The word address is `{entry index, word select}`. Word select 0 is the prefix address, 1 is the mask, 2 is the valid/port word and 3 is the next hop.
- R2: An entry matches only if bit 31 of its valid/port word is 1 and the key equals the prefix address on every bit where the mask is 1. Bits 30:0 of the valid/port word (the port) and key bits where the mask is 0 have no effect.
- R3: Among matching entries, the one with the numerically larger mask (the longer prefix) wins, whatever its position in the table.
- R4: When two matching entries have equal masks, the one with the higher index wins.
- R5: A search reads entries 1 to 2^IDX_W-1 in increasing order, one word per cycle with no gaps, and reads words 0, 1 and 2 of each entry in that order.
- R6: Word 3 (next hop) is never read.
- R7: If no entry matches, the result is index 0.
- R8: `done` rises on the clock edge 3·(2^IDX_W-1)+1 edges after the edge that samples `start`. It stays high for exactly one cycle, and `matchIdx` holds its value until the next accepted start.
- R9: A `start` pulse that arrives while a search is running is ignored. Both the result and the timing of the running search stay the same.
- R10: After reset, `done` and `memRd` are low and `matchIdx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a search |
| searchKey | input | 32 | Address to resolve, sampled with `start` |
| memRd | output | 1 | Read enable to the table RAM |
| memAddr | output | IDX_W+2 | Table word address |
| rdData | input | 32 | RAM read data, valid one cycle after the read |
| done | output | 1 | One-cycle pulse when the result is ready |
| matchIdx | output | IDX_W | Index of the best matching entry, 0 if none |

## Verification
The default table has 4095 entries. The bench uses 4-bit indices, which gives 15 entries, so `done` is due 46 edges after the sampling edge of `start`. The bench counts those edges and checks that `done` arrives on exactly that edge and not just eventually. It then checks the index on that edge, checks that `done` is low one cycle later, and checks that the index is unchanged three cycles after that. The RAM model returns data one edge after each read, the same latency the design assumes. A monitor compares every read address, cycle by cycle, with the expected sequence (entry 1 word 0 upward, skipping word 3), so any gap, reordering or next-hop read is caught in the cycle where it happens. All outputs are sampled one time unit after the rising edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int WORD_W    = 32;
  localparam int VALID_BIT = 31;
  localparam logic [1:0] WSEL_PREFIX = 2'd0;
  localparam logic [1:0] WSEL_MASK   = 2'd1;
  localparam logic [1:0] WSEL_PORT   = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } lpmState_t;

  typedef struct packed {
    logic clear;
    logic capPrefix;
    logic capMask;
    logic evaluate;
  } lpmStrobe_t;
endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  output logic               memRd,
  output logic [IDX_W+1:0]   memAddr,
  output lpmStrobe_t         strb,
  output logic [IDX_W-1:0]   evalIdx,
  output logic               done
);
  localparam logic [IDX_W-1:0] LAST_IDX  = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(1);

  lpmState_t        state;
  logic [IDX_W-1:0] idx;
  logic [1:0]       wordSel;
  logic             phVld;
  logic [1:0]       phWord;
  logic [IDX_W-1:0] phIdx;
  logic             doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      wordSel <= '0;
      phVld   <= 1'b0;
      phWord  <= '0;
      phIdx   <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ  <= 1'b0;
      phVld  <= memRd;
      phWord <= wordSel;
      phIdx  <= idx;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_SCAN;
            idx     <= FIRST_IDX;
            wordSel <= WSEL_PREFIX;
          end
        end
        ST_SCAN: begin
          if (wordSel == WSEL_PORT) begin
            wordSel <= WSEL_PREFIX;
            if (idx == LAST_IDX) state <= ST_DRAIN;
            else                 idx   <= idx + FIRST_IDX;
          end else begin
            wordSel <= wordSel + 2'd1;
          end
        end
        ST_DRAIN: begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    memRd          = (state == ST_SCAN);
    memAddr        = {idx, wordSel};
    strb.clear     = (state == ST_IDLE) && start;
    strb.capPrefix = phVld && (phWord == WSEL_PREFIX);
    strb.capMask   = phVld && (phWord == WSEL_MASK);
    strb.evaluate  = phVld && (phWord == WSEL_PORT);
    evalIdx        = phIdx;
    done           = doneQ;
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_no_nexthop_R6: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memAddr[1:0] != 2'd3));

  assert_scan_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |-> (memAddr > $past(memAddr)));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && start) |=> (idx >= $past(idx)));
endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpmStrobe_t        strb,
  input  logic [WORD_W-1:0] searchKey,
  input  logic [WORD_W-1:0] rdData,
  input  logic [IDX_W-1:0]  evalIdx,
  output logic [IDX_W-1:0]  matchIdx
);
  logic [WORD_W-1:0] keyQ;
  logic [WORD_W-1:0] prefixQ;
  logic [WORD_W-1:0] maskQ;
  logic [WORD_W-1:0] bestMask;
  logic [IDX_W-1:0]  bestIdx;
  logic              entryHit;
  logic              takeEntry;

  always_comb begin
    entryHit  = rdData[VALID_BIT] && (((keyQ ^ prefixQ) & maskQ) == '0);
    takeEntry = strb.evaluate && entryHit && (maskQ >= bestMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ     <= '0;
      prefixQ  <= '0;
      maskQ    <= '0;
      bestMask <= '0;
      bestIdx  <= '0;
    end else begin
      if (strb.clear) begin
        keyQ     <= searchKey;
        bestMask <= '0;
        bestIdx  <= '0;
      end
      if (strb.capPrefix) prefixQ <= rdData;
      if (strb.capMask)   maskQ   <= rdData;
      if (takeEntry) begin
        bestMask <= maskQ;
        bestIdx  <= evalIdx;
      end
    end
  end

  assign matchIdx = bestIdx;

  assert_mask_monotone_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |=> (bestMask >= $past(bestMask)));

  assert_invalid_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evaluate && !rdData[VALID_BIT] && !strb.clear) |=> (matchIdx == $past(matchIdx)));
endmodule

// File: rtl/lpm_scanner.sv
module lpm_scanner
  import lpm_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       searchKey,
  output logic              memRd,
  output logic [IDX_W+1:0]  memAddr,
  input  logic [31:0]       rdData,
  output logic              done,
  output logic [IDX_W-1:0]  matchIdx
);
  lpmStrobe_t       strb;
  logic [IDX_W-1:0] evalIdx;

  lpm_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .memRd   (memRd),
    .memAddr (memAddr),
    .strb    (strb),
    .evalIdx (evalIdx),
    .done    (done)
  );

  lpm_datapath #(.IDX_W(IDX_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .searchKey (searchKey),
    .rdData    (rdData),
    .evalIdx   (evalIdx),
    .matchIdx  (matchIdx)
  );
endmodule

// File: tb/sim_lpm_scanner.sv
module sim_lpm_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 4;
  localparam int ENTRIES    = (1 << IDX_W) - 1;
  localparam int LATENCY    = 3 * ENTRIES + 1;
  localparam int WORDS      = 4 << IDX_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [31:0]       searchKey = '0;
  logic              memRd;
  logic [IDX_W+1:0]  memAddr;
  logic [31:0]       rdData = '0;
  logic              done;
  logic [IDX_W-1:0]  matchIdx;

  logic [31:0] mem [WORDS];
  int testsRun = 0;
  int testsFailed = 0;
  int seqPos = 0;
  bit seqBad = 1'b0;
  int cycles = 0;

  lpm_scanner #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .searchKey(searchKey),
    .memRd(memRd), .memAddr(memAddr), .rdData(rdData),
    .done(done), .matchIdx(matchIdx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // table RAM with one cycle of read latency
  always @(posedge clk) if (memRd) rdData <= mem[memAddr];

  // read-sequence monitor (R5, R6)
  always @(posedge clk) begin
    if (rstN && memRd) begin
      if (int'(memAddr) != ((seqPos / 3) + 1) * 4 + (seqPos % 3)) seqBad = 1'b1;
      seqPos = seqPos + 1;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 200000) begin
      testsFailed = testsFailed + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun = testsRun + 1;
    if (!ok) begin
      testsFailed = testsFailed + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearTable();
    for (int i = 0; i < WORDS; i++) mem[i] = 32'hDEAD_0000 | i;
    for (int e = 0; e <= ENTRIES; e++) mem[e*4+2] = 32'h7FFF_FFFF;
  endtask

  task automatic setEntry(input int idx, input logic [31:0] pfx, input logic [31:0] msk,
                          input logic [31:0] vp);
    mem[idx*4+0] = pfx;
    mem[idx*4+1] = msk;
    mem[idx*4+2] = vp;
    mem[idx*4+3] = 32'hBAD0_0000 | idx;
  endtask

  task automatic runSearch(input logic [31:0] k, input int expIdx, input string tag,
                           input bit inject, input logic [31:0] injKey);
    int lat;
    lat = -1;
    seqPos = 0;
    seqBad = 1'b0;
    @(negedge clk);
    start = 1'b1;
    searchKey = k;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= LATENCY + 20; c++) begin
      @(posedge clk);
      #1;
      if (inject && c == 10) begin start = 1'b1; searchKey = injKey; end
      else if (inject && c == 11) begin start = 1'b0; searchKey = k; end
      if (done) begin lat = c; break; end
    end
    check(lat == LATENCY, {tag, " R8 done latency"}, lat, LATENCY);
    check(int'(matchIdx) == expIdx, {tag, " result index"}, int'(matchIdx), expIdx);
    check(!seqBad && seqPos == 3 * ENTRIES, {tag, " R5 R6 R1 read sequence"}, seqPos, 3 * ENTRIES);
    @(posedge clk);
    #1;
    check(!done, {tag, " R8 done one cycle"}, int'(done), 0);
    repeat (3) @(posedge clk);
    #1;
    check(int'(matchIdx) == expIdx, {tag, " R8 result held"}, int'(matchIdx), expIdx);
  endtask

  task automatic testReset();
    #1;
    check(!done && !memRd && matchIdx == '0, "R10 reset state", int'(matchIdx), 0);
  endtask

  task automatic testNoMatch();
    clearTable();
    runSearch(32'hFFFF_1234, 0, "R7 empty table", 1'b0, '0);
    setEntry(6, 32'hFFFF_1200, 32'hFFFF_FF00, 32'h8000_0001);
    runSearch(32'hFFFF_1334, 0, "R7 R2 masked bit differs", 1'b0, '0);
  endtask

  task automatic testExact();
    clearTable();
    setEntry(5, 32'hFFFF_7AC1, 32'hFFFF_FFFF, 32'h8000_0003);
    runSearch(32'hFFFF_7AC1, 5, "R2 exact match", 1'b0, '0);
  endtask

  task automatic testLongest();
    clearTable();
    setEntry(3,  32'hFFFF_0000, 32'hFFFF_0000, 32'h8000_0001);
    setEntry(9,  32'hFFFF_AB00, 32'hFFFF_FF00, 32'h8000_0002);
    setEntry(12, 32'hFFFF_AB10, 32'hFFFF_FFF0, 32'h8000_0003);
    setEntry(14, 32'hFFFF_A000, 32'hFFFF_F000, 32'h8000_0004);
    runSearch(32'hFFFF_AB5C, 9, "R3 longest prefix wins", 1'b0, '0);
  endtask

  task automatic testTie();
    clearTable();
    setEntry(4,  32'hFFFF_C300, 32'hFFFF_FF00, 32'h8000_0001);
    setEntry(11, 32'hFFFF_C3FF, 32'hFFFF_FF00, 32'h8000_0002);
    runSearch(32'hFFFF_C342, 11, "R4 tie later wins", 1'b0, '0);
  endtask

  task automatic testValidBit();
    clearTable();
    setEntry(2, 32'hFFFF_5500, 32'hFFFF_0000, 32'h8000_0005);
    setEntry(7, 32'hFFFF_5555, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
    runSearch(32'hFFFF_5555, 2, "R2 invalid entry ignored", 1'b0, '0);
  endtask

  task automatic testEdges();
    clearTable();
    setEntry(1,  32'hFFFF_0000, 32'hFFFF_0000, 32'h8000_0000);
    setEntry(15, 32'hFFFF_9999, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    runSearch(32'hFFFF_9999, 15, "R5 last entry", 1'b0, '0);
    runSearch(32'hFFFF_9998, 1, "R5 first entry", 1'b0, '0);
  endtask

  task automatic testBusyStart();
    clearTable();
    setEntry(8,  32'hFFFF_0808, 32'hFFFF_FFFF, 32'h8000_0008);
    setEntry(13, 32'hFFFF_1313, 32'hFFFF_FFFF, 32'h8000_000D);
    runSearch(32'hFFFF_0808, 8, "R9 start while busy", 1'b1, 32'hFFFF_1313);
  endtask

  initial begin
    clearTable();
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testNoMatch();
    testExact();
    testLongest();
    testTie();
    testValidBit();
    testEdges();
    testBusyStart();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule